// File: doc/BRIEF.md
# Double-Buffered Modulo Counter with Overflow Flag

This block is a free-standing count register that wraps at a programmable limit. It raises a sticky overflow flag at each wrap, and it drives an interrupt request from that flag when interrupts are enabled. Software writes the limit as two separate bytes, upper and lower. Each byte lands in a holding buffer first, so a half-written value never reaches the compare logic.

The buffered pair moves into the active limit by one of two rules, chosen by the 2-bit source select:
- **Select `00` (counter stopped):** the transfer happens at once.
- **Select nonzero (counter running):** the transfer waits until the counter steps from one below the new limit onto the new limit. If the active limit is zero (free-running), it waits for the step from all-ones-minus-one to all-ones instead.

While only one of the two bytes has been written, overflow flagging and the interrupt are both held off. An active limit of zero means no limit: the counter rolls through all-ones back to zero. The count, source select, write strobes and flag clear are plain control pins with no handshake. Each write strobe is taken in the cycle it is high.

Top module: `wrapcnt_top`

## Requirements
- R1: After reset, count is 0, the active limit is 0, and the overflow flag and interrupt request are both 0.
- R2: The count rises by one on each cycle where `tick` is high and `clk_sel` is nonzero. It holds when `clk_sel` is `00` or `tick` is low.
- R3: With an active limit M other than 0, a counting step taken while the count equals M loads 0 and sets the overflow flag.
- R4: With an active limit of 0, the count runs up to all-ones. The next step loads 0 and sets the overflow flag.
- R5: A write strobe stores `wr_data` in a buffer byte and leaves the active limit unchanged. `mod_hi_wr` fills bits [CNT_W-1:BYTE_W] and `mod_lo_wr` fills bits [BYTE_W-1:0].
- R6: From the cycle after one byte is written until the cycle the other byte is written, a wrap does not set the flag and the interrupt request is 0.
- R7: With `clk_sel` = `00`, the write that completes the pair loads the active limit, and the new value is visible in the next cycle. Both strobes high in one cycle also complete the pair.
- R8: With `clk_sel` nonzero, a completed pair is held pending. It loads when a counting step moves the count from (buffered value − 1) to the buffered value. The count and the limit show the new value in the same cycle.
- R9: With `clk_sel` nonzero and an active limit of 0, a pending pair loads on the step from all-ones-minus-one to all-ones.
- R10: The overflow flag stays set until `ovf_clr` is high. If a clear and a new overflow fall in the same cycle, the flag stays set.
- R11: `ovf_irq` is high only when the flag is set, `ovf_ie` is high and no byte pair is half written.
- R12: A pending pair loads in the cycle after `clk_sel` returns to `00`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable pulse |
| clk_sel | input | 2 | Source select; `00` stops the counter |
| mod_hi_wr | input | 1 | Write strobe for the upper limit byte |
| mod_lo_wr | input | 1 | Write strobe for the lower limit byte |
| wr_data | input | BYTE_W | Byte written to the limit buffer |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| count | output | CNT_W | Current count |
| modulo | output | CNT_W | Active limit |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with CNT_W = 8 and BYTE_W = 4. These settings keep every width relation of the default build: two byte lanes, and an all-ones free-running wrap. Because a full free-running pass then takes only 256 ticks, the all-ones wrap (R4) and the all-ones-minus-one pending load (R9) can be tested directly. The short limits in the vector table also reach the deferred load (R8), a wrap that occurs while a byte pair is half written (R6), and a clear that lands in the same cycle as an overflow (R10).

// File: rtl/wrapcnt_pkg.sv
package wrapcnt_pkg;
  // Source select encoding; only the all-zero value has meaning (stopped).
  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_A   = 2'b01,
    SRC_B   = 2'b10,
    SRC_C   = 2'b11
  } src_sel_e;
endpackage

// File: rtl/wrapcnt_core.sv
module wrapcnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] active_mod,
  output logic [CNT_W-1:0] count,
  output logic             step,
  output logic             at_wrap
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] wrap_pt;

  // A zero limit behaves as the natural all-ones rollover.
  assign wrap_pt = (active_mod == '0) ? ALL_ONES : active_mod;
  assign at_wrap = (count == wrap_pt);
  assign step    = tick & run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (step) begin
      count <= at_wrap ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/wrapcnt_modbuf.sv
module wrapcnt_modbuf #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              run,
  input  logic              step,
  input  logic              at_wrap,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  active_mod,
  output logic              pair_open
);
  localparam int LANES = CNT_W / BYTE_W;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [LANES-1:0] lane_wr;
  logic [LANES-1:0] seen_q;
  logic [LANES-1:0] seen_nxt;
  logic [CNT_W-1:0] buf_q;
  logic [CNT_W-1:0] buf_nxt;
  logic             armed_q;
  logic             pair_done;
  logic             load_idle;
  logic             load_sync;
  logic [CNT_W-1:0] target;

  // Lane 1 is the upper byte, lane 0 the lower byte.
  assign lane_wr = {wr_hi, wr_lo};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (lane_wr[g]) begin
        lane_q <= wr_data;
      end
    end
    assign buf_q[g*BYTE_W +: BYTE_W]   = lane_q;
    assign buf_nxt[g*BYTE_W +: BYTE_W] = lane_wr[g] ? wr_data : lane_q;
  end

  assign seen_nxt  = seen_q | lane_wr;
  assign pair_done = (&seen_nxt) & (|lane_wr);
  assign pair_open = ^seen_q;

  // Free-running: transfer on the step onto all-ones.
  assign target    = (active_mod == '0) ? ALL_ONES : buf_q;
  assign load_idle = armed_q & ~run;
  assign load_sync = armed_q & step & ~at_wrap & (count == target - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (pair_done) begin
      seen_q <= '0;
    end else begin
      seen_q <= seen_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (pair_done && run) begin
      armed_q <= 1'b1;
    end else if (|lane_wr) begin
      armed_q <= 1'b0;
    end else if (load_idle || load_sync) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_mod <= '0;
    end else if (pair_done && !run) begin
      active_mod <= buf_nxt;
    end else if (load_idle || load_sync) begin
      active_mod <= buf_q;
    end
  end
endmodule

// File: rtl/wrapcnt_flag.sv
module wrapcnt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic at_wrap,
  input  logic pair_open,
  input  logic ovf_ie,
  input  logic ovf_clr,
  output logic ovf_flag,
  output logic ovf_irq
);
  logic set_evt;

  assign set_evt = step & at_wrap & ~pair_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
    end else if (set_evt) begin
      ovf_flag <= 1'b1;
    end else if (ovf_clr) begin
      ovf_flag <= 1'b0;
    end
  end

  assign ovf_irq = ovf_flag & ovf_ie & ~pair_open;
endmodule

// File: rtl/wrapcnt_top.sv
module wrapcnt_top #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        clk_sel,
  input  logic              mod_hi_wr,
  input  logic              mod_lo_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ovf_ie,
  input  logic              ovf_clr,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  modulo,
  output logic              ovf_flag,
  output logic              ovf_irq
);
  import wrapcnt_pkg::*;

  logic run;
  logic step;
  logic at_wrap;
  logic pair_open;

  assign run = (clk_sel != SRC_OFF);

  wrapcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .run        (run),
    .active_mod (modulo),
    .count      (count),
    .step       (step),
    .at_wrap    (at_wrap)
  );

  wrapcnt_modbuf #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_modbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hi      (mod_hi_wr),
    .wr_lo      (mod_lo_wr),
    .wr_data    (wr_data),
    .run        (run),
    .step       (step),
    .at_wrap    (at_wrap),
    .count      (count),
    .active_mod (modulo),
    .pair_open  (pair_open)
  );

  wrapcnt_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .at_wrap   (at_wrap),
    .pair_open (pair_open),
    .ovf_ie    (ovf_ie),
    .ovf_clr   (ovf_clr),
    .ovf_flag  (ovf_flag),
    .ovf_irq   (ovf_irq)
  );
endmodule

// File: rtl/wrapcnt_chk.sv
module wrapcnt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       clk_sel,
  input logic             ovf_ie,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             ovf_irq,
  input logic             step,
  input logic             at_wrap,
  input logic             pair_open
);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b00 || !tick) |=> (count == $past(count)));

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_wrap) |=> (count == '0));

  // R3
  flag_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_wrap && !pair_open) |=> ovf_flag);

  // R6
  open_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_open && !ovf_flag) |=> !ovf_flag);

  // R6
  open_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_open |-> !ovf_irq);

  // R10
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(ovf_clr));

  // R11
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (ovf_ie && ovf_flag));
endmodule

bind wrapcnt_top wrapcnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .clk_sel   (clk_sel),
  .ovf_ie    (ovf_ie),
  .ovf_clr   (ovf_clr),
  .count     (count),
  .ovf_flag  (ovf_flag),
  .ovf_irq   (ovf_irq),
  .step      (step),
  .at_wrap   (at_wrap),
  .pair_open (pair_open)
);

// File: tb/test_wrapcnt_top.sv
`timescale 1ns/1ps
module test_wrapcnt_top;
  localparam int CW = 8;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [1:0]    clk_sel = 2'b00;
  logic          mod_hi_wr = 1'b0;
  logic          mod_lo_wr = 1'b0;
  logic [BW-1:0] wr_data = '0;
  logic          ovf_ie = 1'b0;
  logic          ovf_clr = 1'b0;
  logic [CW-1:0] count;
  logic [CW-1:0] modulo;
  logic          ovf_flag;
  logic          ovf_irq;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wrapcnt_top #(.CNT_W(CW), .BYTE_W(BW)) i_wrapcnt_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clk_sel(clk_sel),
    .mod_hi_wr(mod_hi_wr), .mod_lo_wr(mod_lo_wr), .wr_data(wr_data),
    .ovf_ie(ovf_ie), .ovf_clr(ovf_clr), .count(count), .modulo(modulo),
    .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
  );

  typedef struct packed {
    logic [3:0]    req;
    logic          tk;
    logic [1:0]    sel;
    logic          hw;
    logic          lw;
    logic [BW-1:0] d;
    logic          ie;
    logic          clr;
    logic [CW-1:0] ecnt;
    logic [CW-1:0] emod;
    logic          eflg;
    logic          eirq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{4'd5,  1'b0, 2'd0, 1'b0, 1'b1, 4'h3, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0}, // R5 lower byte only
    '{4'd7,  1'b0, 2'd0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h03, 1'b0, 1'b0}, // R7 pair done, stopped
    '{4'd2,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h01, 8'h03, 1'b0, 1'b0}, // R2
    '{4'd2,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h02, 8'h03, 1'b0, 1'b0},
    '{4'd2,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h03, 8'h03, 1'b0, 1'b0},
    '{4'd3,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 8'h03, 1'b1, 1'b1}, // R3 wrap
    '{4'd2,  1'b0, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 8'h03, 1'b1, 1'b1}, // R2 no tick holds
    '{4'd10, 1'b0, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 8'h00, 8'h03, 1'b0, 1'b0}, // R10 clear
    '{4'd2,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h01, 8'h03, 1'b0, 1'b0},
    '{4'd2,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h02, 8'h03, 1'b0, 1'b0},
    '{4'd2,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h03, 8'h03, 1'b0, 1'b0},
    '{4'd10, 1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 8'h00, 8'h03, 1'b1, 1'b1}, // R10 clear + set
    '{4'd10, 1'b0, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 8'h00, 8'h03, 1'b0, 1'b0},
    '{4'd5,  1'b0, 2'd1, 1'b0, 1'b1, 4'h2, 1'b1, 1'b0, 8'h00, 8'h03, 1'b0, 1'b0}, // R5 single byte
    '{4'd2,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h01, 8'h03, 1'b0, 1'b0},
    '{4'd2,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h02, 8'h03, 1'b0, 1'b0},
    '{4'd2,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h03, 8'h03, 1'b0, 1'b0},
    '{4'd6,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 8'h03, 1'b0, 1'b0}, // R6 wrap inhibited
    '{4'd8,  1'b0, 2'd1, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 8'h03, 1'b0, 1'b0}, // R8 pending
    '{4'd8,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h01, 8'h03, 1'b0, 1'b0},
    '{4'd8,  1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h02, 8'h02, 1'b0, 1'b0}, // R8 load 1->2
    '{4'd11, 1'b1, 2'd1, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 8'h00, 8'h02, 1'b1, 1'b0}, // R11 ie low
    '{4'd11, 1'b0, 2'd1, 1'b0, 1'b1, 4'h3, 1'b1, 1'b0, 8'h00, 8'h02, 1'b1, 1'b0}, // R11 open pair
    '{4'd11, 1'b0, 2'd1, 1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00, 8'h02, 1'b1, 1'b1}  // R11 closed
  };

  task automatic chk(input string req, input string what,
                     input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic tk, input logic [1:0] sel, input logic hw,
                       input logic lw, input logic [BW-1:0] d,
                       input logic ie, input logic clr);
    @(negedge clk);
    tick = tk; clk_sel = sel; mod_hi_wr = hw; mod_lo_wr = lw;
    wr_data = d; ovf_ie = ie; ovf_clr = clr;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick = 1'b0; clk_sel = 2'b00; mod_hi_wr = 1'b0; mod_lo_wr = 1'b0;
    wr_data = '0; ovf_ie = 1'b0; ovf_clr = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_ticks(input int n);
    for (int k = 0; k < n; k++) apply(1'b1, 2'd1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    string tag;
    // R1 reset state
    do_reset();
    chk("R1", "count", count, 8'h00);
    chk("R1", "modulo", modulo, 8'h00);
    chk("R1", "flag", {7'd0, ovf_flag}, 8'h00);
    chk("R1", "irq", {7'd0, ovf_irq}, 8'h00);
    release_reset();

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].tk, VEC[i].sel, VEC[i].hw, VEC[i].lw, VEC[i].d,
            VEC[i].ie, VEC[i].clr);
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      chk(tag, "count", count, VEC[i].ecnt);
      chk(tag, "modulo", modulo, VEC[i].emod);
      chk(tag, "flag", {7'd0, ovf_flag}, {7'd0, VEC[i].eflg});
      chk(tag, "irq", {7'd0, ovf_irq}, {7'd0, VEC[i].eirq});
    end

    // R1 reset in mid-run clears everything
    do_reset();
    chk("R1", "count after reset", count, 8'h00);
    chk("R1", "modulo after reset", modulo, 8'h00);
    chk("R1", "flag after reset", {7'd0, ovf_flag}, 8'h00);
    release_reset();

    // R5 byte placement, R7 load while stopped
    apply(1'b0, 2'd0, 1'b1, 1'b0, 4'h1, 1'b0, 1'b0);
    chk("R5", "modulo after upper only", modulo, 8'h00);
    apply(1'b0, 2'd0, 1'b0, 1'b1, 4'h2, 1'b0, 1'b0);
    chk("R7", "modulo after pair", modulo, 8'h12);
    // R7 both strobes in one cycle
    apply(1'b0, 2'd0, 1'b1, 1'b1, 4'h5, 1'b0, 1'b0);
    chk("R7", "modulo after joint write", modulo, 8'h55);

    // R4 free-running wrap through all-ones
    do_reset();
    release_reset();
    run_ticks(255);
    chk("R4", "count at top", count, 8'hFF);
    chk("R4", "flag before wrap", {7'd0, ovf_flag}, 8'h00);
    run_ticks(1);
    chk("R4", "count after wrap", count, 8'h00);
    chk("R4", "flag after wrap", {7'd0, ovf_flag}, 8'h01);

    // R9 pending load in free-running mode
    do_reset();
    release_reset();
    apply(1'b0, 2'd1, 1'b0, 1'b1, 4'h7, 1'b0, 1'b0);
    apply(1'b0, 2'd1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
    chk("R8", "modulo pending", modulo, 8'h00);
    run_ticks(254);
    chk("R9", "count before load", count, 8'hFE);
    chk("R9", "modulo before load", modulo, 8'h00);
    run_ticks(1);
    chk("R9", "count at load", count, 8'hFF);
    chk("R9", "modulo at load", modulo, 8'h07);

    // R12 pending pair loads when select returns to 00
    do_reset();
    release_reset();
    apply(1'b0, 2'd2, 1'b0, 1'b1, 4'h9, 1'b0, 1'b0);
    apply(1'b0, 2'd2, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
    chk("R12", "modulo still pending", modulo, 8'h00);
    apply(1'b0, 2'd0, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
    chk("R12", "modulo after stop", modulo, 8'h09);
    chk("R2", "count held while stopped", count, 8'h00);

    finish_run();
  end
endmodule